// File: doc/BRIEF.md
# Interrupt Controller Register Bank (64 sources)

This block holds the programmable state of a 64-input interrupt controller and gives software access to it through a simple synchronous register port with byte offsets. Each clock it samples 64 level-sensitive request lines into a pending register. Software can write a 64-bit mask, set or clear one mask bit (or all of them) through two byte-wide command offsets, and program one control byte per source. The block derives a per-source enable bit from whether that source's control byte is nonzero.

The block presents two things to the priority resolver that sits next to it: the gated request vector (pending, not masked, enabled) and the control bytes. The resolver returns the vector it has chosen together with an update strobe. The block keeps that vector and returns it when software reads the acknowledge offset. Reads are registered, so data appears one cycle after the read strobe. The force register has no write path in this block and always reads zero.

Top module: `intc_regbank`

## Requirements
- R1: `pend_q` takes the value of `irq_in` at every clock edge. Offset 0x00 reads pending bits 63:32 and offset 0x04 reads bits 31:0. Writes to 0x00 and 0x04 have no effect.
- R2: Offset 0x08 reads and writes mask bits 63:32, and offset 0x0C reads and writes mask bits 31:0. A mask bit of 1 blocks its source.
- R3: A write to 0x1C with `wdata[6]`=1 sets all 64 mask bits. With `wdata[6]`=0 it sets only the mask bit indexed by `wdata[5:0]` and leaves the others alone.
- R4: A write to 0x1D with `wdata[6]`=1 clears all 64 mask bits. With `wdata[6]`=0 it clears only the mask bit indexed by `wdata[5:0]` and leaves the others alone.
- R5: Offset 0x40+n (n from 0 to 63) holds the control byte of source n. A write stores `wdata[7:0]`. A read returns the byte zero-extended to 32 bits. `ctrl_bytes[8n+7:8n]` presents the byte.
- R6: Source n's enable bit is 1 when its control byte is nonzero. `req_active[n]` = pending[n] AND enable[n] AND NOT mask[n].
- R7: Offsets 0x10 and 0x14 (force register, upper and lower halves) always read zero. Writes to them have no effect.
- R8: When `rslv_upd` is high, the active vector stores `rslv_vec`. Otherwise it holds its value. Offset 0xE0 reads the vector zero-extended. Offsets 0xE1 to 0xE7, 0x1C, 0x1D and every unmapped offset read zero.
- R9: After reset, all mask bits are 1. Pending, enables and all control bytes are 0, the active vector is 24, `rdata` is 0 and `req_active` is 0.
- R10: A write to an offset outside 0x08, 0x0C, 0x1C, 0x1D and 0x40 to 0x7F leaves the mask, the control bytes and the enables unchanged.
- R11: `rdata` presents the register addressed in the cycle of `rd_en` after the next clock edge. It keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level-sensitive request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rslv_upd | input | 1 | Resolver vector update strobe |
| rslv_vec | input | 8 | Vector chosen by the resolver |
| req_active | output | 64 | Gated requests presented to the resolver |
| ctrl_bytes | output | 512 | All control bytes, source n in bits 8n+7:8n |

## Verification
The assertions assume that `irq_in`, `rslv_vec` and the bus fields are synchronous to `clk`. They also assume that `addr` and `wdata` are valid whenever a strobe is high, and that write and read strobes are never high in the same cycle. The bench changes every input only on the falling edge. It issues exactly one access per transaction, and draws its random offsets and command data from the full 8-bit offset space, so unmapped offsets and both command forms are covered. Random vector updates and request patterns fall between accesses and never overlap a strobe on the same edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NSRC   = 64;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CTRL_W = 8;
    localparam int VEC_W  = 8;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int HALF   = NSRC / 2;

    localparam logic [VEC_W-1:0] VEC_RESET = VEC_W'(24);

    localparam logic [ADDR_W-1:0] OFS_PEND_HI  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND_LO  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK_HI  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK_LO  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_FORCE_HI = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FORCE_LO = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MSET     = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_MCLR     = 8'h1D;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_VEC      = 8'hE0;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PEND_HI,
        SEL_PEND_LO,
        SEL_MASK_HI,
        SEL_MASK_LO,
        SEL_FORCE_HI,
        SEL_FORCE_LO,
        SEL_MSET,
        SEL_MCLR,
        SEL_CTRL,
        SEL_VEC
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a >= OFS_CTRL && a < OFS_CTRL + ADDR_W'(NSRC)) begin
            s = SEL_CTRL;
        end else begin
            case (a)
                OFS_PEND_HI:  s = SEL_PEND_HI;
                OFS_PEND_LO:  s = SEL_PEND_LO;
                OFS_MASK_HI:  s = SEL_MASK_HI;
                OFS_MASK_LO:  s = SEL_MASK_LO;
                OFS_FORCE_HI: s = SEL_FORCE_HI;
                OFS_FORCE_LO: s = SEL_FORCE_LO;
                OFS_MSET:     s = SEL_MSET;
                OFS_MCLR:     s = SEL_MCLR;
                OFS_VEC:      s = SEL_VEC;
                default:      s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] zext_byte(input logic [CTRL_W-1:0] b);
        return {{(DATA_W-CTRL_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/intc_mask_reg.sv
module intc_mask_reg
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    output logic [NSRC-1:0] mask_q
);
    // Bit just above the index field selects the all-bits form of a command.
    localparam int ALL_BIT = IDX_W;

    logic [IDX_W-1:0] bit_sel;
    assign bit_sel = req.data[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (req.wr) begin
            case (req.sel)
                SEL_MASK_HI: mask_q[NSRC-1:HALF] <= req.data[HALF-1:0];
                SEL_MASK_LO: mask_q[HALF-1:0]    <= req.data[HALF-1:0];
                SEL_MSET: begin
                    if (req.data[ALL_BIT]) mask_q <= '1;
                    else                   mask_q[bit_sel] <= 1'b1;
                end
                SEL_MCLR: begin
                    if (req.data[ALL_BIT]) mask_q <= '0;
                    else                   mask_q[bit_sel] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    logic unused_hi;
    assign unused_hi = ^req.data[DATA_W-1:ALL_BIT+1] ^ req.rd;

endmodule

// File: rtl/intc_ctrl_bank.sv
module intc_ctrl_bank
    import intc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  reg_sel_e               sel,
    input  logic [IDX_W-1:0]       idx,
    input  logic [CTRL_W-1:0]      wbyte,
    output logic [NSRC*CTRL_W-1:0] ctrl_flat,
    output logic [NSRC-1:0]        en_q
);
    logic hit_ctrl;
    assign hit_ctrl = wr && (sel == SEL_CTRL);

    for (genvar n = 0; n < NSRC; n++) begin : g_src
        logic [CTRL_W-1:0] byte_q;
        logic              sel_me;

        assign sel_me = hit_ctrl && (idx == IDX_W'(n));

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q  <= '0;
                en_q[n] <= 1'b0;
            end else if (sel_me) begin
                byte_q  <= wbyte;
                en_q[n] <= |wbyte;
            end
        end

        assign ctrl_flat[n*CTRL_W +: CTRL_W] = byte_q;
    end

endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
    import intc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd,
    input  reg_sel_e               sel,
    input  logic [IDX_W-1:0]       idx,
    input  logic [NSRC-1:0]        pend,
    input  logic [NSRC-1:0]        mask,
    input  logic [NSRC-1:0]        frc,
    input  logic [NSRC*CTRL_W-1:0] ctrl_flat,
    input  logic [VEC_W-1:0]       vec,
    output logic [DATA_W-1:0]      rdata_q
);
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        case (sel)
            SEL_PEND_HI:  rd_word = pend[NSRC-1:HALF];
            SEL_PEND_LO:  rd_word = pend[HALF-1:0];
            SEL_MASK_HI:  rd_word = mask[NSRC-1:HALF];
            SEL_MASK_LO:  rd_word = mask[HALF-1:0];
            SEL_FORCE_HI: rd_word = frc[NSRC-1:HALF];
            SEL_FORCE_LO: rd_word = frc[HALF-1:0];
            SEL_CTRL:     rd_word = zext_byte(ctrl_flat[idx*CTRL_W +: CTRL_W]);
            SEL_VEC:      rd_word = {{(DATA_W-VEC_W){1'b0}}, vec};
            default:      rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata_q <= '0;
        else if (rd) rdata_q <= rd_word;
    end

endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
    import intc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC-1:0]        irq_in,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    input  logic                   rslv_upd,
    input  logic [VEC_W-1:0]       rslv_vec,
    output logic [NSRC-1:0]        req_active,
    output logic [NSRC*CTRL_W-1:0] ctrl_bytes
);
    bus_req_t        req;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] frc;
    logic [VEC_W-1:0] vec_q;

    // Force register: no write path exists, so it stays at its reset value.
    assign frc = '0;

    always_comb begin
        req.wr   = wr_en;
        req.rd   = rd_en;
        req.sel  = decode_ofs(addr);
        req.idx  = addr[IDX_W-1:0];
        req.data = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            vec_q  <= VEC_RESET;
        end else begin
            pend_q <= irq_in;
            if (rslv_upd) vec_q <= rslv_vec;
        end
    end

    intc_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .mask_q (mask_q)
    );

    intc_ctrl_bank u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr        (req.wr),
        .sel       (req.sel),
        .idx       (req.idx),
        .wbyte     (req.data[CTRL_W-1:0]),
        .ctrl_flat (ctrl_bytes),
        .en_q      (en_q)
    );

    intc_read_mux u_rmux (
        .clk       (clk),
        .rst       (rst),
        .rd        (req.rd),
        .sel       (req.sel),
        .idx       (req.idx),
        .pend      (pend_q),
        .mask      (mask_q),
        .frc       (frc),
        .ctrl_flat (ctrl_bytes),
        .vec       (vec_q),
        .rdata_q   (rdata)
    );

    assign req_active = (pend_q | frc) & en_q & ~mask_q;

endmodule

// File: rtl/intc_regbank_chk.sv
module intc_regbank_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [NSRC-1:0]   irq_in,
    input logic              rslv_upd,
    input logic [VEC_W-1:0]  rslv_vec,
    input logic [NSRC-1:0]   req_active,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   pend_q,
    input logic [VEC_W-1:0]  vec_q
);
    logic mask_ofs;
    logic ack_level_ofs;
    assign mask_ofs = (addr == OFS_MASK_HI) || (addr == OFS_MASK_LO) ||
                      (addr == OFS_MSET) || (addr == OFS_MCLR);
    assign ack_level_ofs = (addr > OFS_VEC) && (addr <= OFS_VEC + 8'd7);

    p_pend_follow_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pend_q == $past(irq_in));

    p_mask_all_set_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == OFS_MSET && wdata[IDX_W] |=> &mask_q);

    p_mask_one_set_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == OFS_MSET && !wdata[IDX_W] |=> mask_q[$past(wdata[IDX_W-1:0])]);

    p_mask_all_clr_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == OFS_MCLR && wdata[IDX_W] |=> mask_q == '0);

    p_mask_one_clr_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == OFS_MCLR && !wdata[IDX_W] |=> !mask_q[$past(wdata[IDX_W-1:0])]);

    p_gate_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (req_active & mask_q) == '0);

    p_gate_pend_r6: assert property (@(posedge clk) disable iff (rst)
        (req_active & ~pend_q) == '0);

    p_vec_load_r8: assert property (@(posedge clk) disable iff (rst)
        rslv_upd |=> vec_q == $past(rslv_vec));

    p_vec_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rslv_upd |=> $stable(vec_q));

    p_ack_level_zero_r8: assert property (@(posedge clk) disable iff (rst)
        rd_en && ack_level_ofs |=> rdata == '0);

    p_mask_untouched_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && mask_ofs) |=> $stable(mask_q));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

bind intc_regbank intc_regbank_chk u_chk (.*);

// File: tb/test_intc_regbank.sv
module test_intc_regbank;
    import intc_pkg::*;

    localparam int CLK_NS = 4;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [NSRC-1:0]        irq_in = '0;
    logic                   wr_en = 1'b0;
    logic                   rd_en = 1'b0;
    logic [ADDR_W-1:0]      addr = '0;
    logic [DATA_W-1:0]      wdata = '0;
    logic [DATA_W-1:0]      rdata;
    logic                   rslv_upd = 1'b0;
    logic [VEC_W-1:0]       rslv_vec = '0;
    logic [NSRC-1:0]        req_active;
    logic [NSRC*CTRL_W-1:0] ctrl_bytes;

    int checks = 0;
    int errors = 0;

    logic [NSRC-1:0]   m_mask;
    logic [NSRC-1:0]   m_pend;
    logic [NSRC-1:0]   m_en;
    logic [CTRL_W-1:0] m_ctrl [NSRC];
    logic [VEC_W-1:0]  m_vec;

    always #(CLK_NS/2) clk = ~clk;

    intc_regbank i_intc_regbank (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .rslv_upd   (rslv_upd),
        .rslv_vec   (rslv_vec),
        .req_active (req_active),
        .ctrl_bytes (ctrl_bytes)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
        if (a >= 8'h40 && a <= 8'h7F) return {24'b0, m_ctrl[a - 8'h40]};
        case (a)
            8'h00:   return m_pend[63:32];
            8'h04:   return m_pend[31:0];
            8'h08:   return m_mask[63:32];
            8'h0C:   return m_mask[31:0];
            8'hE0:   return {24'b0, m_vec};
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [ADDR_W-1:0] a);
        if (a >= 8'h40 && a <= 8'h7F) return "R5";
        case (a)
            8'h00, 8'h04: return "R1";
            8'h08, 8'h0C: return "R2";
            8'h10, 8'h14: return "R7";
            default:      return "R8";
        endcase
    endfunction

    function automatic logic [NSRC-1:0] exp_active();
        return m_pend & m_en & ~m_mask;
    endfunction

    task automatic model_reset();
        m_mask = '1;
        m_pend = '0;
        m_en   = '0;
        m_vec  = 8'd24;
        for (int i = 0; i < NSRC; i++) m_ctrl[i] = '0;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a >= 8'h40 && a <= 8'h7F) begin
            m_ctrl[a - 8'h40] = d[7:0];
            m_en[a - 8'h40]   = |d[7:0];
        end else begin
            case (a)
                8'h08: m_mask[63:32] = d;
                8'h0C: m_mask[31:0]  = d;
                8'h1C: if (d[6]) m_mask = '1; else m_mask[d[5:0]] = 1'b1;
                8'h1D: if (d[6]) m_mask = '0; else m_mask[d[5:0]] = 1'b0;
                default: ;
            endcase
        end
        chk(req_active, exp_active(), "R6");
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(64'(rdata), 64'(exp_read(a)), tag_of(a));
    endtask

    task automatic set_irq(input logic [NSRC-1:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
        m_pend = v;
        chk(req_active, exp_active(), "R6");
    endtask

    task automatic set_vec(input logic [VEC_W-1:0] v);
        @(negedge clk);
        rslv_vec = v; rslv_upd = 1'b1;
        @(negedge clk);
        rslv_upd = 1'b0;
        m_vec = v;
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] held;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        chk(req_active, '0, "R9");
        chk(64'(rdata), '0, "R9");
        chk(64'(ctrl_bytes[63:0]), '0, "R9");
        do_read(8'h08); do_read(8'h0C); do_read(8'h00); do_read(8'hE0);
        do_read(8'h40); do_read(8'h7F);

        // R1: pending follows inputs; writes to pending are ignored
        set_irq(64'hF0F0_0000_0000_00A5);
        do_read(8'h00); do_read(8'h04);
        do_write(8'h00, 32'hFFFF_FFFF); do_write(8'h04, 32'h0);
        do_read(8'h00); do_read(8'h04);

        // R2: mask halves
        do_write(8'h08, 32'h1234_5678); do_write(8'h0C, 32'h0F0F_0F0F);
        do_read(8'h08); do_read(8'h0C);

        // R3 / R4: command forms
        do_write(8'h1D, 32'h0000_0040); do_read(8'h08); do_read(8'h0C);
        do_write(8'h1C, 32'h0000_0005); do_read(8'h0C);
        do_write(8'h1C, 32'h0000_003F); do_read(8'h08);
        do_write(8'h1D, 32'h0000_003F); do_read(8'h08);
        do_write(8'h1C, 32'hFFFF_FF47); do_read(8'h08); do_read(8'h0C);
        do_write(8'h1D, 32'h0000_0080); do_read(8'h0C);

        // R5 / R6: control bytes and derived enables
        do_write(8'h40, 32'hAAAA_AA07); do_write(8'h45, 32'h0000_0001);
        do_write(8'h7F, 32'h0000_00FF);
        do_write(8'h1D, 32'h0000_0040);
        do_read(8'h40); do_read(8'h45); do_read(8'h7F);
        chk(64'(ctrl_bytes[7:0]), 64'h07, "R5");
        set_irq(64'h8000_0000_0000_0021);
        do_write(8'h45, 32'h0000_0100);  // low byte zero disables source 5
        chk(req_active, 64'h8000_0000_0000_0001, "R6");

        // R7: force register reads zero, writes ignored
        do_write(8'h10, 32'hFFFF_FFFF); do_write(8'h14, 32'hFFFF_FFFF);
        do_read(8'h10); do_read(8'h14);

        // R8: vector and zero reads
        set_vec(8'h5A); do_read(8'hE0);
        for (int a = 8'hE1; a <= 8'hE7; a++) do_read(ADDR_W'(a));
        do_read(8'h1C); do_read(8'h1D); do_read(8'hFF);

        // R10: unmapped writes change nothing
        do_write(8'h30, 32'hFFFF_FFFF); do_write(8'hE0, 32'h0);
        do_write(8'h80, 32'h0000_0000); do_write(8'hBF, 32'h0000_0040);
        do_read(8'h08); do_read(8'h0C); do_read(8'h40); do_read(8'hE0);

        // R11: rdata holds between reads
        do_read(8'h40);
        held = rdata;
        @(negedge clk); addr = 8'h08;
        @(negedge clk);
        chk(64'(rdata), 64'(held), "R11");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            op = $urandom % 6;
            a  = ADDR_W'($urandom);
            d  = $urandom;
            if (($urandom % 4) == 0) d = d & 32'h0000_00BF;
            if (($urandom % 3) == 0) d[7:0] = 8'h00;
            case (op)
                0: do_write(($urandom % 2) ? (8'h1C + ADDR_W'($urandom % 2)) : a, d);
                1: do_write(8'h40 + ADDR_W'($urandom % NSRC), d);
                2: do_read(a);
                3: do_read(($urandom % 2) ? 8'h40 + ADDR_W'($urandom % NSRC)
                                          : ADDR_W'(4 * ($urandom % 8)));
                4: set_irq({$urandom, $urandom});
                default: set_vec(VEC_W'($urandom));
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule